// File: doc/BRIEF.md
# Crossbar Memory Column Arbiter

This block is one memory column of a processor-to-memory crossbar. Every processor port brings a request, a direction flag, an address and write data into the column. The column closes at most one crosspoint at a time. It routes the chosen processor's access to a single synchronous memory port, waits out the fixed memory latency, and then acknowledges that processor with read data.

When several processors ask for the same memory column in the same cycle, a rotating-priority arbiter picks one of them. The others keep their requests up and are served in later turns. A requester holds its address, data and direction stable until it sees its acknowledge, and it lowers its request in the cycle that follows. A full crossbar places one instance of this column per memory module.

Top module: `xbc_column`

## Requirements
- R1: During and right after reset, every `p_ack` bit is low, every `p_rdata` lane is zero and `mem_strobe` is low. The rotating priority starts at port 0.
- R2: At most one port holds the grant (closed crosspoint) in any cycle, and at most one `p_ack` bit is high in any cycle.
- R3: A request seen while the column is idle produces `mem_strobe` one cycle later, high for exactly one cycle. In that cycle `mem_addr` equals the granted port's address and `mem_we` equals its write flag (1 = write). On writes, `mem_wdata` equals that port's write data.
- R4: The acknowledge is a single-cycle pulse on the granted port's `p_ack` bit. It comes exactly `MEM_LAT` cycles after the `mem_strobe` cycle.
- R5: On a read, the granted port's `p_rdata` lane equals `mem_rdata` in the acknowledge cycle. On a write, that lane stays zero.
- R6: Ports that are not acknowledged keep `p_ack` low and their `p_rdata` lane at zero. A request that is waiting does not reach the memory port.
- R7: Among simultaneous requesters, the winner is the first requesting port at or after the port that follows the last granted one, with wrap-around from the highest port to port 0.
- R8: A waiting requester is served without lowering its request. No new access starts before the current one is acknowledged. The next strobe comes two cycles after an acknowledge when requests are pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| p_req | input | N_PORTS | Request line per processor |
| p_we | input | N_PORTS | Direction per processor, 1 = write |
| p_addr | input | N_PORTS x 8 | Address per processor |
| p_wdata | input | N_PORTS x 16 | Write data per processor |
| p_ack | output | N_PORTS | Single-cycle completion pulse per processor |
| p_rdata | output | N_PORTS x 16 | Read data per processor, zero unless acknowledged read |
| mem_strobe | output | 1 | One-cycle access strobe to memory |
| mem_we | output | 1 | Memory write enable, valid with strobe |
| mem_addr | output | 8 | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid MEM_LAT cycles after strobe |

## Verification
The strobe is due one cycle after a request is driven into an idle column. When requests are still pending, it is due two cycles after the previous acknowledge. The acknowledge with its read data is due exactly `MEM_LAT` cycles after the strobe. The bench drives inputs and samples outputs on the falling edge. It counts falling edges from each stimulus and checks that nothing appears early. It also checks that the expected event appears in exactly the due cycle. The expected winner and the expected read data come from a bench copy of the priority order and from a shadow memory.

// File: rtl/xbc_pkg.sv
package xbc_pkg;

    localparam int XBC_ADDR_W = 8;
    localparam int XBC_DATA_W = 16;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_ACK   = 2'd3
    } col_state_e;

    typedef struct packed {
        logic                  we;
        logic [XBC_ADDR_W-1:0] addr;
        logic [XBC_DATA_W-1:0] wdata;
    } xp_req_t;

    function automatic int wrap_next(input int idx, input int n);
        return (idx + 1) % n;
    endfunction

endpackage

// File: rtl/xbc_rr_arbiter.sv
module xbc_rr_arbiter #(
    parameter int N_PORTS = 4,
    localparam int IDX_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
    input  logic [N_PORTS-1:0] req,
    input  logic [IDX_W-1:0]   ptr,
    output logic               win_valid,
    output logic [IDX_W-1:0]   win_idx
);

    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        for (int i = 0; i < N_PORTS; i++) begin
            int cand;
            cand = (int'(ptr) + i) % N_PORTS;
            if (!win_valid && req[cand]) begin
                win_valid = 1'b1;
                win_idx   = IDX_W'(cand);
            end
        end
    end

endmodule

// File: rtl/xbc_crosspoint_sel.sv
module xbc_crosspoint_sel
    import xbc_pkg::*;
#(
    parameter int N_PORTS = 4
) (
    input  logic [N_PORTS-1:0]           grant,
    input  xp_req_t [N_PORTS-1:0]        port_req,
    output xp_req_t                      sel
);

    always_comb begin
        sel = '0;
        for (int i = 0; i < N_PORTS; i++) begin
            if (grant[i]) begin
                sel = xp_req_t'(sel | port_req[i]);
            end
        end
    end

endmodule

// File: rtl/xbc_return_path.sv
module xbc_return_path
    import xbc_pkg::*;
#(
    parameter int N_PORTS = 4
) (
    input  logic [N_PORTS-1:0]                 grant,
    input  logic                               ack_en,
    input  logic                               is_read,
    input  logic [XBC_DATA_W-1:0]              mem_rdata,
    output logic [N_PORTS-1:0]                 p_ack,
    output logic [N_PORTS-1:0][XBC_DATA_W-1:0] p_rdata
);

    for (genvar g = 0; g < N_PORTS; g++) begin : g_lane
        assign p_ack[g]   = ack_en & grant[g];
        assign p_rdata[g] = (ack_en && grant[g] && is_read) ? mem_rdata : '0;
    end

endmodule

// File: rtl/xbc_column.sv
module xbc_column
    import xbc_pkg::*;
#(
    parameter int N_PORTS = 4,
    parameter int MEM_LAT = 2
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic [N_PORTS-1:0]                     p_req,
    input  logic [N_PORTS-1:0]                     p_we,
    input  logic [N_PORTS-1:0][XBC_ADDR_W-1:0]     p_addr,
    input  logic [N_PORTS-1:0][XBC_DATA_W-1:0]     p_wdata,
    output logic [N_PORTS-1:0]                     p_ack,
    output logic [N_PORTS-1:0][XBC_DATA_W-1:0]     p_rdata,
    output logic                                   mem_strobe,
    output logic                                   mem_we,
    output logic [XBC_ADDR_W-1:0]                  mem_addr,
    output logic [XBC_DATA_W-1:0]                  mem_wdata,
    input  logic [XBC_DATA_W-1:0]                  mem_rdata
);

    localparam int IDX_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1;
    localparam int CNT_W = $clog2(MEM_LAT + 1) + 1;

    col_state_e           state_q;
    logic [N_PORTS-1:0]   grant_q;
    logic [IDX_W-1:0]     gidx_q;
    logic [IDX_W-1:0]     ptr_q;
    logic [CNT_W-1:0]     cnt_q;

    logic                 win_valid;
    logic [IDX_W-1:0]     win_idx;
    xp_req_t [N_PORTS-1:0] port_req;
    xp_req_t              sel;

    for (genvar g = 0; g < N_PORTS; g++) begin : g_pack
        assign port_req[g] = '{we: p_we[g], addr: p_addr[g], wdata: p_wdata[g]};
    end

    xbc_rr_arbiter #(.N_PORTS(N_PORTS)) u_arb (
        .req       (p_req),
        .ptr       (ptr_q),
        .win_valid (win_valid),
        .win_idx   (win_idx)
    );

    xbc_crosspoint_sel #(.N_PORTS(N_PORTS)) u_xp (
        .grant    (grant_q),
        .port_req (port_req),
        .sel      (sel)
    );

    xbc_return_path #(.N_PORTS(N_PORTS)) u_ret (
        .grant     (grant_q),
        .ack_en    (state_q == ST_ACK),
        .is_read   (!sel.we),
        .mem_rdata (mem_rdata),
        .p_ack     (p_ack),
        .p_rdata   (p_rdata)
    );

    assign mem_strobe = (state_q == ST_ISSUE);
    assign mem_we     = mem_strobe & sel.we;
    assign mem_addr   = sel.addr;
    assign mem_wdata  = sel.wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            grant_q <= '0;
            gidx_q  <= '0;
            ptr_q   <= '0;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (win_valid) begin
                        grant_q <= N_PORTS'(1) << win_idx;
                        gidx_q  <= win_idx;
                        state_q <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    cnt_q   <= CNT_W'(MEM_LAT - 1);
                    state_q <= (MEM_LAT == 1) ? ST_ACK : ST_WAIT;
                end
                ST_WAIT: begin
                    if (cnt_q <= CNT_W'(1)) begin
                        state_q <= ST_ACK;
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                ST_ACK: begin
                    ptr_q   <= IDX_W'(wrap_next(int'(gidx_q), N_PORTS));
                    grant_q <= '0;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Cycles since the last strobe, used to check the acknowledge timing.
    logic [CNT_W-1:0] since_strobe;
    always_ff @(posedge clk) begin
        if (rst) begin
            since_strobe <= '0;
        end else if (mem_strobe) begin
            since_strobe <= CNT_W'(1);
        end else if (since_strobe != '0 && since_strobe <= CNT_W'(MEM_LAT)) begin
            since_strobe <= since_strobe + CNT_W'(1);
        end
    end

    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $past(rst) |-> (p_ack == '0 && !mem_strobe));

    a_r2_single_crosspoint: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_q) && $onehot0(p_ack));

    a_r3_strobe_one_cycle: assert property (@(posedge clk) disable iff (rst)
        mem_strobe |=> !mem_strobe);

    a_r4_ack_latency: assert property (@(posedge clk) disable iff (rst)
        (p_ack != '0) |-> (since_strobe == CNT_W'(MEM_LAT)));

    a_r4_ack_pulse: assert property (@(posedge clk) disable iff (rst)
        (p_ack != '0) |=> (p_ack == '0));

    a_r6_rdata_only_on_ack: assert property (@(posedge clk) disable iff (rst)
        (p_ack == '0) |-> (p_rdata == '0));

endmodule

// File: tb/xbc_column_tb.sv
module xbc_column_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NP  = 4;
    localparam int LAT = 2;
    localparam int AW  = 8;
    localparam int DW  = 16;

    logic                   clk = 1'b0;
    logic                   rst;
    logic [NP-1:0]          p_req;
    logic [NP-1:0]          p_we;
    logic [NP-1:0][AW-1:0]  p_addr;
    logic [NP-1:0][DW-1:0]  p_wdata;
    logic [NP-1:0]          p_ack;
    logic [NP-1:0][DW-1:0]  p_rdata;
    logic                   mem_strobe;
    logic                   mem_we;
    logic [AW-1:0]          mem_addr;
    logic [DW-1:0]          mem_wdata;
    logic [DW-1:0]          mem_rdata;

    int errors = 0;
    int checks = 0;
    int ptr_m  = 0;
    bit done   = 0;

    logic [DW-1:0] mem_arr [256];
    logic [DW-1:0] exp_mem [256];
    logic [DW-1:0] pipe [LAT];

    always #(CLK_PERIOD/2) clk = ~clk;

    xbc_column #(.N_PORTS(NP), .MEM_LAT(LAT)) dut_i (
        .clk(clk), .rst(rst), .p_req(p_req), .p_we(p_we), .p_addr(p_addr),
        .p_wdata(p_wdata), .p_ack(p_ack), .p_rdata(p_rdata),
        .mem_strobe(mem_strobe), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Synchronous memory with fixed latency LAT.
    always @(posedge clk) begin
        if (mem_strobe) begin
            pipe[0] <= mem_arr[mem_addr];
            if (mem_we) mem_arr[mem_addr] <= mem_wdata;
        end
        for (int i = 1; i < LAT; i++) pipe[i] <= pipe[i-1];
    end
    assign mem_rdata = pipe[LAT-1];

    function automatic logic [DW-1:0] init_word(input int a);
        return DW'(a * 16'h0101) ^ 16'h5a5a;
    endfunction

    function automatic int rr_expect(input logic [NP-1:0] pend, input int ptr);
        for (int i = 0; i < NP; i++) begin
            if (pend[(ptr + i) % NP]) return (ptr + i) % NP;
        end
        return -1;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Serve one batch of simultaneous requests and check every due cycle.
    task automatic run_batch(input logic [NP-1:0] pend_in);
        logic [NP-1:0] pend;
        int gap;
        pend  = pend_in;
        p_req = pend_in;
        gap   = 1;
        while (pend != '0) begin
            int w;
            logic [DW-1:0] expv;
            w = rr_expect(pend, ptr_m);
            for (int k = 0; k < gap - 1; k++) begin
                @(negedge clk);
                check(!mem_strobe, "R8 no early strobe", mem_strobe, 0);
            end
            @(negedge clk);
            check(mem_strobe, "R3 strobe due", mem_strobe, 1);
            check(mem_addr == p_addr[w], "R7 winner address", mem_addr, p_addr[w]);
            check(mem_we == p_we[w], "R3 direction", mem_we, p_we[w]);
            if (p_we[w]) check(mem_wdata == p_wdata[w], "R3 write data", mem_wdata, p_wdata[w]);
            expv = exp_mem[p_addr[w]];
            if (p_we[w]) exp_mem[p_addr[w]] = p_wdata[w];
            for (int j = 1; j <= LAT; j++) begin
                @(negedge clk);
                check(!mem_strobe, "R3 strobe single", mem_strobe, 0);
                if (j < LAT) begin
                    check(p_ack == '0, "R4 no early ack", p_ack, 0);
                end else begin
                    check(p_ack == (NP'(1) << w), "R4 ack to winner", p_ack, NP'(1) << w);
                    for (int q = 0; q < NP; q++) begin
                        if (q == w && !p_we[w])
                            check(p_rdata[q] == expv, "R5 read data", p_rdata[q], expv);
                        else
                            check(p_rdata[q] == '0, "R6 lane zero", p_rdata[q], 0);
                    end
                end
            end
            p_req[w] = 1'b0;
            pend[w]  = 1'b0;
            ptr_m    = (w + 1) % NP;
            gap      = 2;
        end
        @(negedge clk);
        check(p_ack == '0 && !mem_strobe, "R4 ack pulse ends", p_ack, 0);
    endtask

    task automatic load_port(input int p, input bit we, input int a, input int d);
        p_we[p]    = we;
        p_addr[p]  = AW'(a);
        p_wdata[p] = DW'(d);
    endtask

    initial begin
        void'($urandom(32'h00c0ffee));
        for (int a = 0; a < 256; a++) begin
            mem_arr[a] = init_word(a);
            exp_mem[a] = init_word(a);
        end
        for (int i = 0; i < LAT; i++) pipe[i] = '0;
        rst = 1'b1; p_req = '0; p_we = '0; p_addr = '0; p_wdata = '0;
        repeat (3) @(negedge clk);
        check(p_ack == '0 && !mem_strobe && p_rdata == '0, "R1 in reset", p_ack, 0);
        rst = 1'b0;
        @(negedge clk);
        check(p_ack == '0 && !mem_strobe && p_rdata == '0, "R1 after reset", p_ack, 0);

        // R7: all four at once, priority starts at port 0
        for (int p = 0; p < NP; p++) load_port(p, p[0], 16 + p, 16'h1000 + p);
        run_batch(4'b1111);
        // Read back the written words
        for (int p = 0; p < NP; p++) load_port(p, 1'b0, 16 + p, 0);
        run_batch(4'b1111);
        // R6: single request on highest port, others idle
        load_port(3, 1'b0, 17, 0);
        run_batch(4'b1000);
        // R7: wrap-around after port 3 picks port 1 before 2
        load_port(1, 1'b1, 40, 16'hbeef);
        load_port(2, 1'b0, 40, 0);
        run_batch(4'b0110);
        // R8: repeated contention on two ports
        load_port(0, 1'b0, 40, 0);
        load_port(2, 1'b1, 41, 16'h7777);
        run_batch(4'b0101);

        for (int n = 0; n < 40; n++) begin
            logic [NP-1:0] pv;
            pv = NP'($urandom % 16);
            for (int p = 0; p < NP; p++)
                load_port(p, $urandom % 2, $urandom % 32, $urandom % 65536);
            if (pv != '0) run_batch(pv);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule